// File: doc/BRIEF.md
# GPIO Bank with Masked Half-Word Writes

This block is a single bank of 32 general-purpose I/O pins controlled through a small memory-mapped register port. Software sets the pin directions and per-pin driver enables, and writes the output values. It reads the pin levels back through a synchronized, read-only view of the pads.

The output value register can be written in two ways. A full-word write replaces all 32 bits. Two half-word masked-write registers each carry a 16-bit mask and 16-bit data, so one or a few pins can change in a single bus write without a read-modify-write sequence. The bank also keeps a per-pin interrupt mask. One register sets mask bits and another clears them, and the current mask can be read back. Edge and level detection are left to a separate block.

Byte offsets are decoded from `addr[5:2]`, and the two lowest address bits are ignored. The register map is:

| Offset | Access | Contents |
|---|---|---|
| 0x00 | write-only | low masked write: mask in [31:16], data in [15:0], applied to pins 15..0 |
| 0x04 | write-only | high masked write: mask in [31:16], data in [15:0], applied to pins 31..16 |
| 0x08 | read/write | full output data word |
| 0x0C | read-only | synchronized pad inputs |
| 0x10 | read/write | direction (1 = output) |
| 0x14 | read/write | driver enable (1 = enabled) |
| 0x18 | read-only | interrupt mask (1 = masked) |
| 0x1C | write-1-to-clear | interrupt mask bits |
| 0x20 | write-1-to-set | interrupt mask bits |

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, the output data, direction, driver-enable and interrupt-mask registers all read 0, and `pad_out` and `pad_oe` are 0.
- R2: A write to offset 0x08 replaces all 32 output data bits, and a read of 0x08 returns that value.
- R3: A write to offset 0x00 updates output pin i (i in 0..15) to `wdata[i]` when `wdata[16+i]` is 0. When `wdata[16+i]` is 1, pin i keeps its value. Pins 16..31 are unchanged.
- R4: A write to offset 0x04 updates output pin 16+i to `wdata[i]` when `wdata[16+i]` is 0. When `wdata[16+i]` is 1, pin 16+i keeps its value. Pins 0..15 are unchanged.
- R5: `pad_out` always equals the output data register.
- R6: Offset 0x10 (direction, 1 = output) and offset 0x14 (driver enable, 1 = enabled) are read/write. `pad_oe` is the bitwise AND of the two registers.
- R7: A level on `pad_in` appears on `pin_in` and in reads of offset 0x0C after exactly two rising clock edges. A write to 0x0C has no effect.
- R8: Writing to offset 0x20 sets each interrupt-mask bit whose `wdata` bit is 1. Mask bits written as 0 keep their value.
- R9: Writing to offset 0x1C clears each interrupt-mask bit whose `wdata` bit is 1. Mask bits written as 0 keep their value.
- R10: Offset 0x18 returns the current interrupt mask (1 = masked), and a write to 0x18 has no effect.
- R11: Reads of offsets 0x00, 0x04 and unmapped offsets 0x24..0x3C return 0, and `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` when `rd_en` is high |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad driver enables |
| pin_in | output | 32 | Synchronized per-pin input levels |

## Verification
The assertions check on every cycle the register-update rules:
- the result of a full-word write;
- the keep-or-replace rule of both masked half-word writes, including that the other half stays put;
- the set-only and clear-only behaviour of the two interrupt-mask write ports;
- the stability of the mask under writes to its read-only status offset.

Only the bench scenarios can show the following:
- the reset values;
- the exact two-edge latency of the input synchronizer;
- that writes to read-only offsets leave the readback unchanged;
- the AND of direction and driver enable on the pads;
- that write-only and unmapped offsets read as zero.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe,
  output logic [31:0]       pin_in
);
  localparam int WI = ADDR_W - 2;
  localparam logic [WI-1:0] A_LO   = WI'(0);
  localparam logic [WI-1:0] A_HI   = WI'(1);
  localparam logic [WI-1:0] A_DATA = WI'(2);
  localparam logic [WI-1:0] A_IN   = WI'(3);
  localparam logic [WI-1:0] A_DIR  = WI'(4);
  localparam logic [WI-1:0] A_OEN  = WI'(5);
  localparam logic [WI-1:0] A_MSK  = WI'(6);
  localparam logic [WI-1:0] A_IEN  = WI'(7);
  localparam logic [WI-1:0] A_IDIS = WI'(8);

  logic [WI-1:0] widx;
  logic [31:0]   dout, dir, oen, imask, sync1, sync2;
  logic [15:0]   wmask, wval;

  assign widx  = addr[ADDR_W-1:2];
  assign wmask = wdata[31:16];
  assign wval  = wdata[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      dir   <= '0;
      oen   <= '0;
      imask <= '0;
    end else if (wr_en) begin
      case (widx)
        A_LO:    dout[15:0]  <= (dout[15:0] & wmask) | (wval & ~wmask);
        A_HI:    dout[31:16] <= (dout[31:16] & wmask) | (wval & ~wmask);
        A_DATA:  dout  <= wdata;
        A_DIR:   dir   <= wdata;
        A_OEN:   oen   <= wdata;
        A_IEN:   imask <= imask & ~wdata;
        A_IDIS:  imask <= imask | wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (widx)
        A_DATA:  rdata = dout;
        A_IN:    rdata = sync2;
        A_DIR:   rdata = dir;
        A_OEN:   rdata = oen;
        A_MSK:   rdata = imask;
        default: rdata = '0;
      endcase
    end
  end

  assign pad_out = dout;
  assign pad_oe  = dir & oen;
  assign pin_in  = sync2;

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_DATA) |=> pad_out == $past(wdata));

  assert_low_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_LO) |=>
      pad_out == {$past(pad_out[31:16]),
                  ($past(pad_out[15:0]) & $past(wdata[31:16])) |
                  ($past(wdata[15:0]) & ~$past(wdata[31:16]))});

  assert_high_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_HI) |=>
      pad_out == {($past(pad_out[31:16]) & $past(wdata[31:16])) |
                  ($past(wdata[15:0]) & ~$past(wdata[31:16])),
                  $past(pad_out[15:0])});

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_IDIS) |=>
      ((imask & $past(wdata)) == $past(wdata)) &&
      ((imask & ~$past(wdata)) == ($past(imask) & ~$past(wdata))));

  assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_IEN) |=>
      ((imask & $past(wdata)) == '0) &&
      ((imask & ~$past(wdata)) == ($past(imask) & ~$past(wdata))));

  assert_mask_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_MSK) |=> $stable(imask));
endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe, pin_in;
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_in(pin_in));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h08, v); check("R1 data", v, 32'h0);
    rd(6'h10, v); check("R1 dir", v, 32'h0);
    rd(6'h14, v); check("R1 oe", v, 32'h0);
    rd(6'h18, v); check("R1 mask", v, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
  endtask

  task automatic t_full;
    logic [31:0] v;
    wr(6'h08, 32'hA5A5_0F0F);
    rd(6'h08, v); check("R2 readback", v, 32'hA5A5_0F0F);
    check("R5 pad_out", pad_out, 32'hA5A5_0F0F);
  endtask

  task automatic t_low_mask;
    logic [31:0] v;
    wr(6'h08, 32'hFFFF_0000);
    wr(6'h00, {16'hFF00, 16'h1234});
    rd(6'h08, v); check("R3 low masked", v, 32'hFFFF_0034);
    check("R5 pad_out after low", pad_out, 32'hFFFF_0034);
    wr(6'h00, {16'hFFFF, 16'hFFFF});
    check("R3 full mask keeps", pad_out, 32'hFFFF_0034);
  endtask

  task automatic t_high_mask;
    logic [31:0] v;
    wr(6'h04, {16'h000F, 16'hABCD});
    rd(6'h08, v); check("R4 high masked", v, 32'hABCF_0034);
    wr(6'h04, {16'h0000, 16'h0001});
    check("R4 no mask", pad_out, 32'h0001_0034);
  endtask

  task automatic t_dir_oe;
    logic [31:0] v;
    wr(6'h10, 32'h0000_FFFF);
    wr(6'h14, 32'h00FF_00FF);
    rd(6'h10, v); check("R6 dir readback", v, 32'h0000_FFFF);
    rd(6'h14, v); check("R6 oe readback", v, 32'h00FF_00FF);
    check("R6 pad_oe", pad_oe, 32'h0000_00FF);
  endtask

  task automatic t_input;
    logic [31:0] v;
    @(negedge clk); pad_in = 32'h1234_5678;
    @(negedge clk); check("R7 one edge", pin_in, 32'h0);
    @(negedge clk); check("R7 two edges", pin_in, 32'h1234_5678);
    rd(6'h0C, v); check("R7 read input", v, 32'h1234_5678);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, v); check("R7 write ignored", v, 32'h1234_5678);
    check("R7 pad_out intact", pad_out, 32'h0001_0034);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(6'h20, 32'h0000_00F0);
    rd(6'h18, v); check("R8 set", v, 32'h0000_00F0);
    wr(6'h20, 32'h0F00_0000);
    rd(6'h18, v); check("R8 zeros keep", v, 32'h0F00_00F0);
    wr(6'h1C, 32'h0000_0030);
    rd(6'h18, v); check("R9 clear", v, 32'h0F00_00C0);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); check("R10 status ro", v, 32'h0F00_00C0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(6'h00, v); check("R11 low masked reads 0", v, 32'h0);
    rd(6'h04, v); check("R11 high masked reads 0", v, 32'h0);
    rd(6'h24, v); check("R11 0x24", v, 32'h0);
    rd(6'h3C, v); check("R11 0x3C", v, 32'h0);
    @(negedge clk); addr = 6'h08; #1;
    check("R11 no rd_en", rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_low_mask();
    t_high_mask();
    t_dir_oe();
    t_input();
    t_mask();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule